// File: doc/BRIEF.md
# Sprite and Sample DMA Arbiter

This block stalls the CPU and carries out two kinds of direct memory transfer on its behalf. A sprite transfer copies a whole page of 256 bytes, byte by byte, from the CPU address space into a single fixed write port. A sample transfer fetches one byte for an audio channel and hands it over with a load strobe. Both share one engine. It opens every stall with a halt cycle, keeps reads on get cycles and writes on put cycles, and inserts alignment cycles where the parity does not fit.

The CPU side supplies the address of its pending read and a cycle parity bit that toggles every clock. While `cpu_halt` is high the block owns the bus. A cycle with nothing to transfer repeats a dummy read of the CPU's pending address, unless that address is one of the two controller ports, whose reads have side effects. Memory contents sit outside the block and return on `bus_rdata` in the cycle of the read.

Top module: `dma_arb`

## Requirements
- R1: After reset `cpu_halt`, `bus_rd`, `bus_wr`, `smp_load` and `spr_done` are all 0.
- R2: The first stalled cycle of every stall is a halt cycle that reads `cpu_addr`, whatever that address is.
- R3: Sprite reads and the sample fetch happen only when `put_phase` is 0 (get). Sprite writes happen only when `put_phase` is 1 (put), always to address 0x2004, and carry the byte read in the preceding get.
- R4: Sprite reads go to `{spr_page, n}` with n rising from 0 to 255, and the n-th write carries the byte at that address.
- R5: A sprite transfer alone stalls the CPU for 513 cycles when its halt cycle falls on a put and 514 when it falls on a get. After 512 transfers `spr_done` pulses for one cycle, in the cycle after the final write.
- R6: A sample transfer passes a halt cycle and one dummy cycle before its fetch, which it makes on the next get. Alone it stalls for 3 cycles (halt on get) or 4 (halt on put). The fetched byte appears on `smp_data` with a one-cycle `smp_load` in the following cycle.
- R7: A sample transfer that is ready on a get takes that get instead of the sprite read. The sprite transfer is pushed back by two cycles, so a put-aligned sprite stall grows to 515.
- R8: Dummy and alignment cycles read `cpu_addr`. When `cpu_addr` is 0x4016 or 0x4017 they do not read (the halt read still does).
- R9: `cpu_halt` falls only when neither transfer is outstanding, and the bus is then left undriven. A `spr_start` that arrives while a sprite transfer runs is ignored.
- R10: `bus_rd` and `bus_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| put_phase | input | 1 | Cycle parity: 0 get, 1 put |
| cpu_addr | input | 16 | Address of the CPU's pending read |
| spr_start | input | 1 | One-cycle request for a sprite page copy |
| spr_page | input | 8 | Source page of the sprite copy |
| smp_go | input | 1 | One-cycle request for a sample byte fetch |
| smp_addr | input | 16 | Address of the sample byte |
| bus_rdata | input | 8 | Read data returned in the cycle of a read |
| cpu_halt | output | 1 | CPU stalled while high |
| bus_addr | output | 16 | Transfer bus address |
| bus_rd | output | 1 | Bus read this cycle |
| bus_wr | output | 1 | Bus write this cycle |
| bus_wdata | output | 8 | Bus write data |
| smp_data | output | 8 | Fetched sample byte |
| smp_load | output | 1 | One-cycle strobe for `smp_data` |
| spr_done | output | 1 | One-cycle pulse when the sprite copy ends |

## Verification
Sprite copies are started with the halt cycle on a put and on a get. The 513/514 stall lengths and the number of reads at the CPU address separate a correct alignment cycle from a missing or extra one. Lone sample fetches at both parities expose the halt and dummy settling count. A sample request placed mid-copy shows whether it steals a get from the sprite reads, and whether the two-cycle penalty and the data order hold. A pending address of 0x4016 tells the suppressed dummy reads apart from the halt read, and a second start during a copy shows that the page is not overwritten.

// File: rtl/dma_arb_pkg.sv
// Shared types for the DMA arbiter: the kind of bus cycle chosen each clock.
package dma_arb_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE   = 3'd0,  // CPU owns the bus
        ACT_HALT   = 3'd1,  // first stalled cycle, reads the CPU address
        ACT_DUMMY  = 3'd2,  // filler or alignment cycle
        ACT_SMP    = 3'd3,  // sample byte fetch
        ACT_SPR_RD = 3'd4,  // sprite source read
        ACT_SPR_WR = 3'd5   // sprite write to the fixed port
    } dma_act_e;
endpackage

// File: rtl/dma_spr_engine.sv
// Sprite page copy engine.
// Counts 2*2**OFS_W transfers: even counts are reads, odd counts are writes.
// Holds the last read byte for the following write. Assumes the selector only
// issues a read on an even count and a write on an odd count.
module dma_spr_engine
    import dma_arb_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [PAGE_W-1:0]        page,
    input  dma_act_e                 act,
    input  logic [DATA_W-1:0]        rdata,
    output logic                     busy,
    output logic                     xfer_odd,
    output logic [PAGE_W+OFS_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]        wdata,
    output logic                     done
);
    localparam int CNT_W = OFS_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] hold_q;

    // Start, advance and finish the page copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            page_q <= '0;
            hold_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    page_q <= page;
                    cnt_q  <= '0;
                end
            end else if (act == ACT_SPR_RD) begin
                hold_q <= rdata;
                cnt_q  <= cnt_q + 1'b1;
            end else if (act == ACT_SPR_WR) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == {CNT_W{1'b1}}) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Source address and write data views of the engine state.
    always_comb begin
        xfer_odd = cnt_q[0];
        rd_addr  = {page_q, cnt_q[CNT_W-1:1]};
        wdata    = hold_q;
    end
endmodule

// File: rtl/dma_smp_engine.sv
// Single-byte sample fetch engine.
// A request must see SETTLE stalled cycles (halt, then dummy) before it may
// fetch. The fetched byte is registered with a one-cycle load strobe.
module dma_smp_engine
    import dma_arb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SETTLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr_in,
    input  dma_act_e          act,
    input  logic [DATA_W-1:0] rdata,
    output logic              pend,
    output logic              ready,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data,
    output logic              load
);
    localparam int STG_W = $clog2(SETTLE + 1);

    logic [STG_W-1:0] stage_q;

    // Accept a request, count settling cycles, capture the fetched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            addr_q  <= '0;
            stage_q <= '0;
            data    <= '0;
            load    <= 1'b0;
        end else begin
            load <= 1'b0;
            if (!pend) begin
                if (go) begin
                    pend    <= 1'b1;
                    addr_q  <= addr_in;
                    stage_q <= '0;
                end
            end else if (act == ACT_SMP) begin
                pend <= 1'b0;
                data <= rdata;
                load <= 1'b1;
            end else if (act != ACT_IDLE && stage_q != STG_W'(SETTLE)) begin
                stage_q <= stage_q + 1'b1;
            end
        end
    end

    // Fetch allowed once the settling cycles have elapsed.
    always_comb ready = pend && (stage_q == STG_W'(SETTLE));
endmodule

// File: rtl/dma_cycle_sel.sv
// Per-cycle arbiter. Chooses the bus action from the engine states and the
// cycle parity, and drives the transfer bus. Assumes put_phase alternates
// every clock. The first stalled cycle is always a halt cycle.
module dma_cycle_sel
    import dma_arb_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int unsigned SPR_PORT = 'h2004,
    parameter bit          QUIET_EN = 1'b1,
    parameter int unsigned QUIET_A  = 'h4016,
    parameter int unsigned QUIET_B  = 'h4017
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_phase,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              spr_busy,
    input  logic              spr_odd,
    input  logic [ADDR_W-1:0] spr_addr,
    input  logic [DATA_W-1:0] spr_wdata,
    input  logic              smp_pend,
    input  logic              smp_ready,
    input  logic [ADDR_W-1:0] smp_addr,
    output dma_act_e          act,
    output logic              stall,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata
);
    logic engaged_q;
    logic quiet;

    // Pending-address filter for read-sensitive ports.
    generate
        if (QUIET_EN) begin : g_quiet
            assign quiet = (cpu_addr == ADDR_W'(QUIET_A)) || (cpu_addr == ADDR_W'(QUIET_B));
        end else begin : g_loud
            assign quiet = 1'b0;
        end
    endgenerate

    // Remember that the halt cycle of this stall has been spent.
    always_ff @(posedge clk) begin
        if (!rst_n) engaged_q <= 1'b0;
        else        engaged_q <= (act != ACT_IDLE);
    end

    // Priority choice: halt, sample on get, sprite read on get, write on put.
    always_comb begin
        stall = spr_busy || smp_pend;
        if (!stall)                               act = ACT_IDLE;
        else if (!engaged_q)                      act = ACT_HALT;
        else if (!put_phase && smp_ready)         act = ACT_SMP;
        else if (!put_phase && spr_busy && !spr_odd) act = ACT_SPR_RD;
        else if (put_phase && spr_busy && spr_odd)   act = ACT_SPR_WR;
        else                                      act = ACT_DUMMY;
    end

    // Bus drive for the chosen action.
    always_comb begin
        bus_addr  = cpu_addr;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        unique case (act)
            ACT_HALT:   bus_rd = 1'b1;
            ACT_DUMMY:  bus_rd = !quiet;
            ACT_SMP: begin
                bus_addr = smp_addr;
                bus_rd   = 1'b1;
            end
            ACT_SPR_RD: begin
                bus_addr = spr_addr;
                bus_rd   = 1'b1;
            end
            ACT_SPR_WR: begin
                bus_addr  = ADDR_W'(SPR_PORT);
                bus_wr    = 1'b1;
                bus_wdata = spr_wdata;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dma_arb.sv
// Top of the sprite/sample DMA arbiter. Joins the two engines through the
// per-cycle selector. Assumes the CPU holds its pending read while cpu_halt
// is high and reissues it afterwards.
module dma_arb
    import dma_arb_pkg::*;
#(
    parameter int          PAGE_W   = 8,
    parameter int          OFS_W    = 8,
    parameter int          DATA_W   = 8,
    parameter int          SETTLE   = 2,
    parameter int unsigned SPR_PORT = 'h2004,
    parameter bit          QUIET_EN = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     put_phase,
    input  logic [PAGE_W+OFS_W-1:0]  cpu_addr,
    input  logic                     spr_start,
    input  logic [PAGE_W-1:0]        spr_page,
    input  logic                     smp_go,
    input  logic [PAGE_W+OFS_W-1:0]  smp_addr,
    input  logic [DATA_W-1:0]        bus_rdata,
    output logic                     cpu_halt,
    output logic [PAGE_W+OFS_W-1:0]  bus_addr,
    output logic                     bus_rd,
    output logic                     bus_wr,
    output logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        smp_data,
    output logic                     smp_load,
    output logic                     spr_done
);
    localparam int ADDR_W = PAGE_W + OFS_W;

    dma_act_e          act;
    logic              spr_busy, spr_odd;
    logic [ADDR_W-1:0] spr_rd_addr;
    logic [DATA_W-1:0] spr_wdata;
    logic              smp_pend, smp_ready;
    logic [ADDR_W-1:0] smp_addr_q;

    dma_spr_engine #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_spr (
        .clk(clk), .rst_n(rst_n), .start(spr_start), .page(spr_page), .act(act),
        .rdata(bus_rdata), .busy(spr_busy), .xfer_odd(spr_odd),
        .rd_addr(spr_rd_addr), .wdata(spr_wdata), .done(spr_done)
    );

    dma_smp_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETTLE(SETTLE)) u_smp (
        .clk(clk), .rst_n(rst_n), .go(smp_go), .addr_in(smp_addr), .act(act),
        .rdata(bus_rdata), .pend(smp_pend), .ready(smp_ready), .addr_q(smp_addr_q),
        .data(smp_data), .load(smp_load)
    );

    dma_cycle_sel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPR_PORT(SPR_PORT),
                    .QUIET_EN(QUIET_EN)) u_sel (
        .clk(clk), .rst_n(rst_n), .put_phase(put_phase), .cpu_addr(cpu_addr),
        .spr_busy(spr_busy), .spr_odd(spr_odd), .spr_addr(spr_rd_addr),
        .spr_wdata(spr_wdata), .smp_pend(smp_pend), .smp_ready(smp_ready),
        .smp_addr(smp_addr_q), .act(act), .stall(cpu_halt), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata)
    );
endmodule

// File: rtl/dma_arb_chk.sv
// Port-level property checker for dma_arb, attached by bind below.
module dma_arb_chk #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int unsigned SPR_PORT = 'h2004
) (
    input logic              clk,
    input logic              rst_n,
    input logic              put_phase,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_halt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              smp_load,
    input logic              spr_done
);
    logic quiet;
    always_comb quiet = (cpu_addr == ADDR_W'('h4016)) || (cpu_addr == ADDR_W'('h4017));

    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_wr_on_put_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (put_phase && bus_addr == ADDR_W'(SPR_PORT)));
    p_halt_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> (bus_rd && bus_addr == cpu_addr));
    p_load_after_get_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_load |-> ($past(bus_rd) && !$past(put_phase) && $past(cpu_halt)));
    p_done_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        spr_done |-> $past(bus_wr));
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && $past(cpu_halt) && quiet && bus_addr == cpu_addr) |-> !bus_rd);
    p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_halt |-> (!bus_rd && !bus_wr));
    p_wdata_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |-> (bus_wdata == '0));
endmodule

bind dma_arb dma_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPR_PORT(SPR_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .put_phase(put_phase), .cpu_addr(cpu_addr),
    .cpu_halt(cpu_halt), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .smp_load(smp_load), .spr_done(spr_done)
);

// File: tb/dma_arb_tb.sv
// Directed bench for dma_arb: one task per scenario, memory modeled here.
module dma_arb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        put_phase;
    logic [15:0] cpu_addr = 16'h8123;
    logic        spr_start = 1'b0;
    logic [7:0]  spr_page = 8'h00;
    logic        smp_go = 1'b0;
    logic [15:0] smp_addr = 16'h0000;
    logic [7:0]  bus_rdata;
    logic        cpu_halt, bus_rd, bus_wr, smp_load, spr_done;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, smp_data;

    int checks = 0;
    int errors = 0;
    bit ended = 1'b0;

    // Monitor results of one stall.
    int stall_n, wr_n, rd_n, cpu_rd_n, fetch_n, load_n, done_n;

    always #2 clk = ~clk;

    always @(posedge clk) put_phase <= rst_n ? ~put_phase : 1'b0;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    assign bus_rdata = mem_f(bus_addr);

    dma_arb u_dut (
        .clk(clk), .rst_n(rst_n), .put_phase(put_phase), .cpu_addr(cpu_addr),
        .spr_start(spr_start), .spr_page(spr_page), .smp_go(smp_go),
        .smp_addr(smp_addr), .bus_rdata(bus_rdata), .cpu_halt(cpu_halt),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .smp_data(smp_data), .smp_load(smp_load), .spr_done(spr_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Wait so that the halt cycle of a request pulsed now lands on the wanted parity.
    task automatic align(input bit halt_on_put);
        @(negedge clk);
        if (put_phase == halt_on_put) @(negedge clk);
    endtask

    // Follow one stall from its first cycle to the first free cycle.
    task automatic watch(input logic [7:0] page, input logic [15:0] saddr);
        bit prev_wr = 1'b0;
        bit prev_fetch = 1'b0;
        bit first = 1'b1;
        stall_n = 0; wr_n = 0; rd_n = 0; cpu_rd_n = 0; fetch_n = 0; load_n = 0; done_n = 0;
        forever begin
            if (smp_load) begin
                load_n++;
                chk(prev_fetch, "R6 load follows fetch", 0, 1);
                chk(smp_data == mem_f(saddr), "R6 sample byte", smp_data, mem_f(saddr));
            end
            if (spr_done) begin
                done_n++;
                chk(prev_wr && wr_n == 256, "R5 done after last write", wr_n, 256);
            end
            if (!cpu_halt) break;
            if (first) chk(bus_rd && bus_addr == cpu_addr, "R2 halt read", bus_addr, cpu_addr);
            first = 1'b0;
            stall_n++;
            chk(!(bus_rd && bus_wr), "R10 exclusive", {bus_rd, bus_wr}, 0);
            prev_fetch = 1'b0;
            if (bus_wr) begin
                chk(put_phase && bus_addr == 16'h2004, "R3 write on put to port", bus_addr, 16'h2004);
                chk(bus_wdata == mem_f({page, wr_n[7:0]}), "R4 write data", bus_wdata,
                    mem_f({page, wr_n[7:0]}));
                wr_n++;
            end else if (bus_rd && bus_addr == cpu_addr) begin
                cpu_rd_n++;
            end else if (bus_rd && bus_addr == saddr) begin
                chk(!put_phase, "R6 fetch on get", put_phase, 0);
                fetch_n++;
                prev_fetch = 1'b1;
            end else if (bus_rd) begin
                chk(!put_phase && bus_addr == {page, rd_n[7:0]}, "R4 read order",
                    bus_addr, {page, rd_n[7:0]});
                rd_n++;
            end
            prev_wr = bus_wr;
            @(negedge clk);
        end
        chk(!bus_rd && !bus_wr, "R9 bus released", {bus_rd, bus_wr}, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!cpu_halt && !bus_rd && !bus_wr && !smp_load && !spr_done, "R1 reset state",
            {cpu_halt, bus_rd, bus_wr, smp_load, spr_done}, 0);
    endtask

    task automatic t_sprite(input bit halt_on_put, input logic [7:0] page, input int exp_len,
                            input int exp_cpu_rd, input bit restart);
        align(halt_on_put);
        spr_page = page; spr_start = 1'b1;
        @(negedge clk);
        spr_start = 1'b0;
        fork
            watch(page, 16'hFFFF);
            if (restart) begin
                repeat (20) @(negedge clk);
                spr_page = 8'h33; spr_start = 1'b1;   // R9: must be ignored
                @(negedge clk);
                spr_start = 1'b0;
            end
        join
        chk(stall_n == exp_len, "R5 sprite stall length", stall_n, exp_len);
        chk(wr_n == 256 && rd_n == 256, "R4 transfer count", wr_n, 256);
        chk(done_n == 1, "R5 one done pulse", done_n, 1);
        chk(cpu_rd_n == exp_cpu_rd, "R8 reads of pending address", cpu_rd_n, exp_cpu_rd);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_sample(input bit halt_on_put, input int exp_len, input int exp_cpu_rd);
        align(halt_on_put);
        smp_addr = 16'hC0F3; smp_go = 1'b1;
        @(negedge clk);
        smp_go = 1'b0;
        watch(8'h00, 16'hC0F3);
        chk(stall_n == exp_len, "R6 sample stall length", stall_n, exp_len);
        chk(load_n == 1 && fetch_n == 1, "R6 one fetch and load", load_n, 1);
        chk(cpu_rd_n == exp_cpu_rd, "R6 halt and dummy reads", cpu_rd_n, exp_cpu_rd);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_collide();
        align(1'b1);
        spr_page = 8'h07; spr_start = 1'b1;
        @(negedge clk);
        spr_start = 1'b0;
        fork
            watch(8'h07, 16'hC1A9);
            begin
                repeat (10) @(negedge clk);
                smp_addr = 16'hC1A9; smp_go = 1'b1;
                @(negedge clk);
                smp_go = 1'b0;
            end
        join
        chk(stall_n == 515, "R7 collided stall length", stall_n, 515);
        chk(fetch_n == 1 && load_n == 1, "R7 sample served mid copy", fetch_n, 1);
        chk(wr_n == 256 && rd_n == 256, "R7 sprite intact", wr_n, 256);
        chk(cpu_rd_n == 2, "R7 one extra dummy", cpu_rd_n, 2);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sprite(1'b1, 8'h02, 513, 1, 1'b0);
        t_sprite(1'b0, 8'h02, 514, 2, 1'b0);
        t_sprite(1'b1, 8'h05, 513, 1, 1'b1);
        cpu_addr = 16'h4016;
        t_sprite(1'b0, 8'h03, 514, 1, 1'b0);
        cpu_addr = 16'h4017;
        t_sample(1'b1, 4, 1);
        cpu_addr = 16'h8123;
        t_sample(1'b0, 3, 2);
        t_sample(1'b1, 4, 3);
        t_collide();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule